// File: doc/BRIEF.md
# Display pixel word unpacker

This block sits between a pixel FIFO and the data pins of a parallel display. It accepts 32-bit memory words over a valid/ready handshake and breaks each word into pixels. A word-length code and a four-bit byte-valid mask decide how many pixels a word holds and which bytes carry them. Each pixel is then shaped for the selected output bus width, which is independent of the source format. On the narrowest bus a pixel goes out as several byte beats.

The block counts pixels along a line and lines within a frame against a transfer-count word. It marks the final beat of each line and of each frame. A flush input empties the block and resets both counters, so that software can reprogram the format without leaving stale pixels behind. The configuration inputs are expected to stay constant between flushes.

Top module: `pixel_word_unpacker`

## Requirements
- R1: After reset, `pix_valid_o`, `eol_o` and `eof_o` are low and `word_ready_o` is high.
- R2: With word-length code 0 (RGB565) and mask 0xF, each word gives two pixels. Bits 15:0 go out first, then bits 31:16.
- R3: With code 0, the low halfword is emitted only when mask bits 1:0 are both set, and the high halfword only when mask bits 3:2 are both set. A word with neither halfword valid is consumed and produces no output.
- R4: Any nonzero code selects 24-bit pixels. The pixel is bits 23:0 of the word and is emitted only when mask bits 2:0 are all set. Bits 31:24 and mask bit 3 have no effect.
- R5: Bus code 3 (24-bit) drives a 24-bit pixel unchanged. It drives an RGB565 pixel as {R5,000,G6,00,B5,000}.
- R6: Bus code 2 (18-bit) drives the upper six bits of each 8-bit channel on bits 17:0, as {R,G,B}. An RGB565 pixel is first widened as in R5. Bits 23:18 are zero.
- R7: Bus code 0 (16-bit) drives an RGB565 pixel unchanged. It drives a 24-bit pixel as {R[7:3],G[7:2],B[7:3]}. Bits 23:16 are zero.
- R8: Bus code 1 (8-bit) sends each pixel as byte beats on bits 7:0, least significant byte first. An RGB565 pixel takes two beats and a 24-bit pixel takes three. Bits 23:8 are zero.
- R9: While `pix_valid_o` is high and `pix_ready_i` is low, the output holds. No accepted pixel is lost or duplicated.
- R10: `eol_o` rises on the last beat of the Nth pixel of a line, where N is bits 15:0 of `xfer_count_i`. The pixel count then returns to zero.
- R11: `eof_o` rises together with `eol_o` on line M of the frame, where M is bits 31:16 of `xfer_count_i`. The line count then returns to zero.
- R12: A cycle with `flush_i` high empties the block, so `pix_valid_o` is low in the next cycle. The same cycle zeroes both counters. Words offered during the flush are accepted and dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Discard buffered data and clear counters |
| word_len_i | input | 2 | Source pixel format: 0 = RGB565, other = 24-bit |
| byte_mask_i | input | 4 | Byte-valid packaging mask |
| bus_sel_i | input | 2 | Output bus: 0 = 16, 1 = 8, 2 = 18, 3 = 24 bits |
| xfer_count_i | input | 2*CNT_W | Lines per frame (upper half), pixels per line (lower half) |
| word_i | input | 32 | Memory word |
| word_valid_i | input | 1 | Word offered |
| word_ready_o | output | 1 | Word taken this cycle |
| pix_o | output | 24 | Display data bus |
| pix_valid_o | output | 1 | Beat present on `pix_o` |
| pix_ready_i | input | 1 | Display takes the beat |
| eol_o | output | 1 | Last beat of a line |
| eof_o | output | 1 | Last beat of a frame |

## Verification
The bench sweeps every pairing of source format and bus width under random backpressure and random masks. It compares each beat with a model of the channel mapping. A swapped halfword order or a byte order reversed on the 8-bit bus shows up as a data miscompare on the first pixel. A design that drops a word with a partial mask, or that emits its ignored bytes, goes out of step with the expected beat queue. Short line and frame lengths of one to four put end-of-line and end-of-frame on every few pixels, which exposes off-by-one counts and missed wraps. A flush in the middle of a phase catches designs that keep a pixel or a stale count across the flush.

// File: rtl/pixel_word_unpacker.sv
module pixel_word_unpacker #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic [1:0]         word_len_i,
  input  logic [3:0]         byte_mask_i,
  input  logic [1:0]         bus_sel_i,
  input  logic [2*CNT_W-1:0] xfer_count_i,
  input  logic [31:0]        word_i,
  input  logic               word_valid_i,
  output logic               word_ready_o,
  output logic [23:0]        pix_o,
  output logic               pix_valid_o,
  input  logic               pix_ready_i,
  output logic               eol_o,
  output logic               eof_o
);
  localparam logic [1:0] BUS16 = 2'd0, BUS8 = 2'd1, BUS18 = 2'd2, BUS24 = 2'd3;

  logic [31:0]      word_q;
  logic             full_q, half_q;
  logic [1:0]       beat_q;
  logic [CNT_W-1:0] pcnt_q, lcnt_q;

  wire fmt16 = (word_len_i == 2'd0);
  wire lo_ok = fmt16 ? (&byte_mask_i[1:0]) : (&byte_mask_i[2:0]);
  wire hi_ok = fmt16 & (&byte_mask_i[3:2]);

  wire [CNT_W-1:0] per_line  = xfer_count_i[CNT_W-1:0];
  wire [CNT_W-1:0] per_frame = xfer_count_i[2*CNT_W-1:CNT_W];
  wire line_end  = (pcnt_q == per_line - CNT_W'(1));
  wire frame_end = (lcnt_q == per_frame - CNT_W'(1));

  logic [23:0] raw;
  assign raw = fmt16 ? {8'h00, (half_q ? word_q[31:16] : word_q[15:0])} : word_q[23:0];

  wire last_beat = (bus_sel_i != BUS8) | (beat_q == (fmt16 ? 2'd1 : 2'd2));
  wire fire      = full_q & pix_ready_i;
  wire pix_done  = fire & last_beat;
  wire word_done = pix_done & (half_q | ~hi_ok);

  assign word_ready_o = flush_i | ~full_q | word_done;
  wire accept = word_valid_i & word_ready_o & ~flush_i;

  always_comb begin
    case (bus_sel_i)
      BUS16: pix_o = fmt16 ? {8'h00, raw[15:0]}
                           : {8'h00, raw[23:19], raw[15:10], raw[7:3]};
      BUS8: begin
        case (beat_q)
          2'd0:    pix_o = {16'h0000, raw[7:0]};
          2'd1:    pix_o = {16'h0000, raw[15:8]};
          default: pix_o = {16'h0000, raw[23:16]};
        endcase
      end
      BUS18: pix_o = fmt16 ? {6'h00, raw[15:11], 1'b0, raw[10:5], raw[4:0], 1'b0}
                           : {6'h00, raw[23:18], raw[15:10], raw[7:2]};
      default: pix_o = fmt16 ? {raw[15:11], 3'b000, raw[10:5], 2'b00, raw[4:0], 3'b000}
                             : raw;
    endcase
  end

  assign pix_valid_o = full_q;
  assign eol_o = full_q & last_beat & line_end;
  assign eof_o = eol_o & frame_end;

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      full_q <= 1'b0;
      half_q <= 1'b0;
      beat_q <= 2'd0;
      pcnt_q <= '0;
      lcnt_q <= '0;
      if (!rst_n) word_q <= '0;
    end else begin
      if (fire && !last_beat) beat_q <= beat_q + 2'd1;
      if (pix_done) begin
        beat_q <= 2'd0;
        if (!word_done) half_q <= 1'b1;
        if (line_end) begin
          pcnt_q <= '0;
          lcnt_q <= frame_end ? '0 : lcnt_q + CNT_W'(1);
        end else begin
          pcnt_q <= pcnt_q + CNT_W'(1);
        end
      end
      if (accept && (lo_ok || hi_ok)) begin
        word_q <= word_i;
        full_q <= 1'b1;
        half_q <= ~lo_ok;
        beat_q <= 2'd0;
      end else if (word_done) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

module pixel_word_unpacker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush_i,
  input logic [1:0]  bus_sel_i,
  input logic        word_ready_o,
  input logic [23:0] pix_o,
  input logic        pix_valid_o,
  input logic        pix_ready_i,
  input logic        eol_o,
  input logic        eof_o
);
  AST_EOF_WITH_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> eol_o) else $error("eof without eol"); // R11
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !pix_valid_o) else $error("data after flush"); // R12
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && !pix_ready_i && !flush_i) |=> (pix_valid_o && $stable(pix_o) && $stable(eol_o)))
    else $error("output moved under backpressure"); // R9
  AST_BYTE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && bus_sel_i == 2'd1) |-> (pix_o[23:8] == 16'h0)) else $error("8-bit bus upper bits"); // R8
  AST_EIGHTEEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && bus_sel_i == 2'd2) |-> (pix_o[23:18] == 6'h0)) else $error("18-bit bus upper bits"); // R6
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid_o |-> word_ready_o) else $error("not ready while empty"); // R1
endmodule

bind pixel_word_unpacker pixel_word_unpacker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .bus_sel_i(bus_sel_i),
  .word_ready_o(word_ready_o), .pix_o(pix_o), .pix_valid_o(pix_valid_o),
  .pix_ready_i(pix_ready_i), .eol_o(eol_o), .eof_o(eof_o)
);

// File: tb/tb_pixel_word_unpacker.sv
module tb_pixel_word_unpacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic [1:0]  word_len_i = 2'd0;
  logic [3:0]  byte_mask_i = 4'hF;
  logic [1:0]  bus_sel_i = 2'd3;
  logic [31:0] xfer_count_i = 32'h0001_0001;
  logic [31:0] word_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic [23:0] pix_o;
  logic        pix_valid_o;
  logic        pix_ready_i = 1'b0;
  logic        eol_o, eof_o;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  logic [25:0] expq[$];
  int pc = 0, lc = 0;

  always #4 clk = ~clk;

  pixel_word_unpacker dut (.*);

  function automatic logic [23:0] beat_value(logic [23:0] raw, bit f16, logic [1:0] bus, int idx);
    logic [7:0] r, g, b;
    if (f16) begin
      r = {raw[15:11], 3'b0}; g = {raw[10:5], 2'b0}; b = {raw[4:0], 3'b0};
    end else begin
      r = raw[23:16]; g = raw[15:8]; b = raw[7:0];
    end
    case (bus)
      2'd3: return {r, g, b};
      2'd2: return {6'b0, r[7:2], g[7:2], b[7:2]};
      2'd0: return {8'b0, r[7:3], g[7:2], b[7:3]};
      default: return {16'b0, raw[idx*8 +: 8]};
    endcase
  endfunction

  task automatic push_pixel(logic [23:0] raw, bit f16);
    int nb = (bus_sel_i == 2'd1) ? (f16 ? 2 : 3) : 1;
    int ppl = int'(xfer_count_i[15:0]);
    int lpf = int'(xfer_count_i[31:16]);
    for (int k = 0; k < nb; k++) begin
      bit le = (k == nb - 1) && (pc == ppl - 1);
      bit fe = le && (lc == lpf - 1);
      expq.push_back({le, fe, beat_value(raw, f16, bus_sel_i, k)});
    end
    if (pc == ppl - 1) begin
      pc = 0;
      lc = (lc == lpf - 1) ? 0 : lc + 1;
    end else pc++;
  endtask

  task automatic push_word(logic [31:0] w);
    bit f16 = (word_len_i == 2'd0);
    if (f16) begin
      if (byte_mask_i[1:0] == 2'b11) push_pixel({8'h0, w[15:0]}, 1'b1);
      if (byte_mask_i[3:2] == 2'b11) push_pixel({8'h0, w[31:16]}, 1'b1);
    end else if (byte_mask_i[2:0] == 3'b111) begin
      push_pixel(w[23:0], 1'b0);
    end
  endtask

  function automatic string fmt_tag();
    if (word_len_i != 2'd0) return "R4";
    return (byte_mask_i == 4'hF) ? "R2" : "R3";
  endfunction

  function automatic string bus_tag();
    case (bus_sel_i)
      2'd0: return "R7";
      2'd1: return "R8";
      2'd2: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check_beat();
    logic [25:0] e;
    vectors++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL R9 unexpected beat: actual %h expected none", pix_o);
      return;
    end
    e = expq.pop_front();
    if (pix_o !== e[23:0]) begin
      errors++;
      $display("FAIL %s %s data: actual %h expected %h", fmt_tag(), bus_tag(), pix_o, e[23:0]);
    end
    if (eol_o !== e[25]) begin
      errors++;
      $display("FAIL R10 eol: actual %b expected %b", eol_o, e[25]);
    end
    if (eof_o !== e[24]) begin
      errors++;
      $display("FAIL R11 eof: actual %b expected %b", eof_o, e[24]);
    end
  endtask

  task automatic step(bit do_flush, int vpct, int rpct);
    bit was_flush;
    @(negedge clk);
    was_flush = flush_i;
    flush_i = do_flush;
    word_valid_i = ($urandom % 100) < vpct;
    word_i = $urandom;
    pix_ready_i = ($urandom % 100) < rpct;
    #1;
    if (was_flush) begin
      vectors++;
      if (pix_valid_o !== 1'b0) begin
        errors++;
        $display("FAIL R12 valid after flush: actual %b expected 0", pix_valid_o);
      end
    end
    if (do_flush) begin
      expq.delete();
      pc = 0; lc = 0;
    end else begin
      if (pix_valid_o && pix_ready_i) check_beat();
      if (word_valid_i && word_ready_o) push_word(word_i);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    vectors++;
    if (pix_valid_o !== 1'b0 || word_ready_o !== 1'b1 || eol_o !== 1'b0 || eof_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual v=%b r=%b eol=%b eof=%b expected 0 1 0 0",
               pix_valid_o, word_ready_o, eol_o, eof_o);
    end
    rst_n = 1'b1;
    for (int ph = 0; ph < 28; ph++) begin
      @(negedge clk);
      bus_sel_i = 2'(ph % 4);
      word_len_i = ((ph / 4) % 2 == 0) ? 2'd0 : ((ph % 3 == 0) ? 2'd2 : 2'd3);
      if (ph < 8) byte_mask_i = (word_len_i == 2'd0) ? 4'hF : 4'h7;
      else if (ph < 16) byte_mask_i = (word_len_i == 2'd0) ? ((ph % 2) ? 4'h3 : 4'hC) : 4'hF;
      else byte_mask_i = 4'($urandom);
      xfer_count_i = {16'(1 + $urandom % 3), 16'(1 + $urandom % 4)};
      step(1'b1, 50, 50);
      for (int c = 0; c < 300; c++) begin
        step(c == 150, 70, (c < 100) ? 90 : 50);
      end
      for (int c = 0; c < 30; c++) step(1'b0, 0, 100);
      vectors++;
      if (expq.size() != 0 || pix_valid_o !== 1'b0) begin
        errors++;
        $display("FAIL R9 beats lost: actual %0d pending expected 0", expq.size());
      end
      expq.delete();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule